// File: doc/BRIEF.md
# Decimating Binary-Coefficient Correlator

This block slides a fixed pattern of one-bit weights across a stream of signed 8-bit samples. It produces one correlation result for every sample it accepts. The stream is assumed to be oversampled by a parameter factor. The block keeps a history of `OS_FACTOR * NUM_TAP` samples, but it correlates only the newest sample and every `OS_FACTOR`-th older one. This lets a receiver find a known pattern, such as a preamble or a spreading code, at the symbol rate while samples arrive at the higher rate.

Each weight is a single bit, and a parameter sets how the bit is read. In gating mode a 1 adds the sample and a 0 adds nothing. In antipodal mode a 1 adds the sample and a 0 subtracts it. Two weight patterns live in a small bank, each padded to a power-of-two length. A write port replaces a whole pattern, and a select input names the pattern to apply. The block takes the pattern snapshot, and the select, at the moment a sample is accepted. A write therefore never disturbs a sum that is already in flight.

Top module: `corr_bincoef`

## Requirements
- R1: `res_valid` is high for exactly one cycle, two clock edges after each edge on which `smp_valid` is high, and is low otherwise; one result is produced per accepted sample.
- R2: The result for an accepted sample equals the sum over k = 0..NUM_TAP-1 of w_k applied to h[k*OS_FACTOR], where h[0] is that sample, h[j] is the j-th older accepted sample, and w_k is bit k of the active pattern.
- R3: With `MODE = COEF_ANTIPODAL`, a weight bit of 1 adds the sample and a weight bit of 0 adds its two's-complement negation.
- R4: With `MODE = COEF_GATING`, a weight bit of 1 adds the sample and a weight bit of 0 adds zero.
- R5: After reset, `res_valid` and `res_value` are 0, every stored pattern is all zeros, and every history entry is zero, so history positions not yet filled count as zero-valued samples.
- R6: Cycles with `smp_valid` low leave the history unchanged; gaps in the stream do not shift samples.
- R7: A pattern write stores `pat_wr_bits` into section `pat_wr_slot`. Bits at positions NUM_TAP and above (the zero padding up to the next power of two) are discarded and never add to any result in either mode.
- R8: The pattern applied to a sample is the section named by `pat_sel` on the accepting edge, as it stood before any write on that same edge. A write takes effect from the next accepted sample.
- R9: `res_value` is two's complement, SAMPLE_W + ceil(log2(NUM_TAP)) + 1 bits wide, and holds the exact sum without overflow, including all-(-128) inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Accept `smp_data` on this edge |
| smp_data | input | SAMPLE_W | Signed input sample |
| pat_wr_en | input | 1 | Write a whole weight pattern |
| pat_wr_slot | input | SEL_W | Bank section receiving the write |
| pat_wr_bits | input | PAT_W | Pattern bits, bit k weights tap k; upper padding ignored |
| pat_sel | input | SEL_W | Section applied to the sample accepted on this edge |
| res_valid | output | 1 | Result strobe |
| res_value | output | ACC_W | Signed correlation result |

## Verification
The assertions assume that reset is held for at least one edge before traffic starts. They also assume that `pat_sel` and `pat_wr_slot` only name sections that exist, so `NUM_SEQ` is a power of two. The stimulus applies reset before any traffic and addresses only the two implemented sections. It then sweeps every 6-bit pattern under both weight readings, with pseudo-random samples, idle gaps, writes that coincide with accepted samples, and full-scale negative and positive inputs. Expected sums come from a bench-side shift history and arithmetic over the decimated positions.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // How a single weight bit is interpreted by the summation stage.
    typedef enum logic {
        COEF_GATING    = 1'b0,   // 1 -> +x, 0 -> 0
        COEF_ANTIPODAL = 1'b1    // 1 -> +x, 0 -> -x
    } coef_mode_e;

    // Width of a result that can hold NUM_TAP signed samples without wrap.
    function automatic int acc_width(input int sample_w, input int num_tap);
        return sample_w + $clog2(num_tap) + 1;
    endfunction

    // Padded section length: next power of two at or above NUM_TAP.
    function automatic int pat_width(input int num_tap);
        return 1 << $clog2(num_tap);
    endfunction

endpackage

// File: rtl/corr_history.sv
module corr_history #(
    parameter int SAMPLE_W  = 8,
    parameter int NUM_TAP   = 6,
    parameter int OS_FACTOR = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               smp_valid,
    input  logic [SAMPLE_W-1:0]                smp_data,
    output logic [NUM_TAP-1:0][SAMPLE_W-1:0]   tap_sel,
    output logic                               fresh
);

    localparam int DEPTH = OS_FACTOR * NUM_TAP;

    typedef struct packed {
        logic [DEPTH-1:0][SAMPLE_W-1:0] line;
        logic                           fresh;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fresh = smp_valid;
        if (smp_valid) begin
            st_d.line[0] = smp_data;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.line[i] = st_q.line[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Decimated pick: newest entry, then every OS_FACTOR-th older entry.
    for (genvar k = 0; k < NUM_TAP; k++) begin : g_pick
        assign tap_sel[k] = st_q.line[k*OS_FACTOR];
    end

    assign fresh = st_q.fresh;

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(st_q.line)); // R6

    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> (tap_sel[0] == $past(smp_data))); // R2

endmodule

// File: rtl/corr_pattern_bank.sv
module corr_pattern_bank #(
    parameter int NUM_TAP = 6,
    parameter int NUM_SEQ = 2,
    parameter int PAT_W   = 8,
    parameter int SEL_W   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_slot,
    input  logic [PAT_W-1:0]   wr_bits,
    input  logic [SEL_W-1:0]   sel,
    input  logic               accept,
    output logic [NUM_TAP-1:0] active
);

    localparam logic [PAT_W-1:0] KEEP_MASK = PAT_W'((64'd1 << NUM_TAP) - 64'd1);

    typedef struct packed {
        logic [NUM_SEQ-1:0][PAT_W-1:0] bank;
        logic [NUM_TAP-1:0]            act;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Snapshot uses the bank as it was before any same-edge write.
        if (accept) begin
            st_d.act = st_q.bank[sel][NUM_TAP-1:0];
        end
        if (wr_en) begin
            st_d.bank[wr_slot] = wr_bits & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active = st_q.act;

    AST_PAT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(active)); // R8

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_pad_chk
        AST_PAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (st_q.bank[s] & ~KEEP_MASK) == '0); // R7
    end

endmodule

// File: rtl/corr_mac.sv
module corr_mac
    import corr_pkg::*;
#(
    parameter int         SAMPLE_W = 8,
    parameter int         NUM_TAP  = 6,
    parameter coef_mode_e MODE     = COEF_ANTIPODAL,
    parameter int         ACC_W    = 12
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             fire,
    input  logic [NUM_TAP-1:0][SAMPLE_W-1:0] taps,
    input  logic [NUM_TAP-1:0]               weights,
    output logic                             res_valid,
    output logic [ACC_W-1:0]                 res_value
);

    localparam int BOUND = NUM_TAP * (1 << (SAMPLE_W - 1));

    typedef struct packed {
        logic             valid;
        logic [ACC_W-1:0] value;
    } mac_t;

    mac_t st_d, st_q;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] term;

    always_comb begin
        sum  = '0;
        term = '0;
        for (int k = 0; k < NUM_TAP; k++) begin
            term = {{(ACC_W-SAMPLE_W){taps[k][SAMPLE_W-1]}}, taps[k]};
            if (weights[k]) begin
                sum = sum + term;
            end else if (MODE == COEF_ANTIPODAL) begin
                sum = sum - term;
            end
        end
        st_d       = st_q;
        st_d.valid = fire;
        if (fire) begin
            st_d.value = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_value = st_q.value;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($signed(res_value) <= BOUND && $signed(res_value) >= -BOUND)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(res_value)); // R1

endmodule

// File: rtl/corr_bincoef.sv
module corr_bincoef
    import corr_pkg::*;
#(
    parameter int         SAMPLE_W  = 8,
    parameter int         NUM_TAP   = 6,
    parameter int         OS_FACTOR = 2,
    parameter int         NUM_SEQ   = 2,
    parameter coef_mode_e MODE      = COEF_ANTIPODAL,
    localparam int        SEL_W     = $clog2(NUM_SEQ),
    localparam int        PAT_W     = pat_width(NUM_TAP),
    localparam int        ACC_W     = acc_width(SAMPLE_W, NUM_TAP)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                pat_wr_en,
    input  logic [SEL_W-1:0]    pat_wr_slot,
    input  logic [PAT_W-1:0]    pat_wr_bits,
    input  logic [SEL_W-1:0]    pat_sel,
    output logic                res_valid,
    output logic [ACC_W-1:0]    res_value
);

    logic [NUM_TAP-1:0][SAMPLE_W-1:0] tap_sel;
    logic                             fresh;
    logic [NUM_TAP-1:0]               weights;

    corr_history #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_TAP  (NUM_TAP),
        .OS_FACTOR(OS_FACTOR)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .tap_sel  (tap_sel),
        .fresh    (fresh)
    );

    corr_pattern_bank #(
        .NUM_TAP(NUM_TAP),
        .NUM_SEQ(NUM_SEQ),
        .PAT_W  (PAT_W),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (pat_wr_en),
        .wr_slot(pat_wr_slot),
        .wr_bits(pat_wr_bits),
        .sel    (pat_sel),
        .accept (smp_valid),
        .active (weights)
    );

    corr_mac #(
        .SAMPLE_W(SAMPLE_W),
        .NUM_TAP (NUM_TAP),
        .MODE    (MODE),
        .ACC_W   (ACC_W)
    ) u_mac (
        .clk      (clk),
        .rst      (rst),
        .fire     (fresh),
        .taps     (tap_sel),
        .weights  (weights),
        .res_valid(res_valid),
        .res_value(res_value)
    );

    AST_LAT_FIXED: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ##2 res_valid); // R1

    AST_LAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ##2 !res_valid); // R1

endmodule

// File: tb/tb_corr_bincoef.sv
module tb_corr_bincoef;
    import corr_pkg::*;

    localparam int NT    = 6;
    localparam int OS    = 2;
    localparam int DEPTH = NT * OS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = '0;
    logic        pat_wr_en = 1'b0;
    logic [0:0]  pat_wr_slot = '0;
    logic [7:0]  pat_wr_bits = '0;
    logic [0:0]  pat_sel = '0;
    logic        vs, vu;
    logic [11:0] rs, ru;

    always #2 clk = ~clk;   // 250 MHz

    corr_bincoef #(.NUM_TAP(NT), .OS_FACTOR(OS), .MODE(COEF_ANTIPODAL)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .pat_wr_en(pat_wr_en), .pat_wr_slot(pat_wr_slot), .pat_wr_bits(pat_wr_bits),
        .pat_sel(pat_sel), .res_valid(vs), .res_value(rs));

    corr_bincoef #(.NUM_TAP(NT), .OS_FACTOR(OS), .MODE(COEF_GATING)) dut_u (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .pat_wr_en(pat_wr_en), .pat_wr_slot(pat_wr_slot), .pat_wr_bits(pat_wr_bits),
        .pat_sel(pat_sel), .res_valid(vu), .res_value(ru));

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    int hist [DEPTH];
    bit [7:0] bank [2];
    bit pv [2];
    int ps [2];
    int pu [2];
    bit [31:0] seed = 32'h1234_5678;

    function automatic int next_sample();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]) - 128;
    endfunction

    task automatic check_out(bit ev, int es, int eu);
        checks++;
        if (vs !== ev) begin
            errors++;
            $display("FAIL R1 antipodal valid: got %0b expected %0b", vs, ev);
        end else if (ev && $signed(rs) != es) begin
            errors++;
            $display("FAIL %s (R3) antipodal result: got %0d expected %0d", cur_req, $signed(rs), es);
        end
        checks++;
        if (vu !== ev) begin
            errors++;
            $display("FAIL R1 gating valid: got %0b expected %0b", vu, ev);
        end else if (ev && $signed(ru) != eu) begin
            errors++;
            $display("FAIL %s (R4) gating result: got %0d expected %0d", cur_req, $signed(ru), eu);
        end
    endtask

    // Called at a falling edge: check, update model, drive, advance.
    task automatic step(bit v, int s, bit wr, int slot, int bits, int sel);
        int es = 0;
        int eu = 0;
        bit [7:0] w;
        check_out(pv[1], ps[1], pu[1]);
        if (v) begin
            for (int i = DEPTH - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = s;
            w = bank[sel];
            for (int k = 0; k < NT; k++) begin
                es += w[k] ? hist[k*OS] : -hist[k*OS];
                eu += w[k] ? hist[k*OS] : 0;
            end
        end
        pv[1] = pv[0]; ps[1] = ps[0]; pu[1] = pu[0];
        pv[0] = v;     ps[0] = es;    pu[0] = eu;
        if (wr) bank[slot] = 8'(bits) & 8'h3F;
        smp_valid   = v;
        smp_data    = 8'(s);
        pat_wr_en   = wr;
        pat_wr_slot = 1'(slot);
        pat_wr_bits = 8'(bits);
        pat_sel     = 1'(sel);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL R1 watchdog expired: got hang expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) hist[i] = 0;
        bank[0] = '0; bank[1] = '0;
        pv[0] = 0; pv[1] = 0; ps[0] = 0; ps[1] = 0; pu[0] = 0; pu[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5: reset state, then partial fill with all-zero patterns
        cur_req = "R5";
        checks++;
        if (vs !== 1'b0 || rs !== '0 || vu !== 1'b0 || ru !== '0) begin
            errors++;
            $display("FAIL R5 reset outputs: got %0b/%0d expected 0/0", vs, rs);
        end
        for (int i = 0; i < 8; i++) step(1, next_sample(), 0, 0, 0, 0);
        idle(3);

        // R2 R3 R4: every 6-bit pattern, streaming samples
        cur_req = "R2";
        for (int c = 0; c < 64; c++) begin
            step(0, 0, 1, 0, c, 0);
            for (int i = 0; i < 13; i++) step(1, next_sample(), 0, 0, 0, 0);
        end
        idle(3);

        // R6: idle gaps between accepted samples
        cur_req = "R6";
        step(0, 0, 1, 0, 6'h2D, 0);
        for (int i = 0; i < 40; i++) begin
            step(1, next_sample(), 0, 0, 0, 0);
            idle(i % 3);
        end

        // R7: padding bits set in writes must not contribute
        cur_req = "R7";
        for (int c = 0; c < 16; c++) begin
            step(0, 0, 1, 0, (c * 5) | 8'hC0, 0);
            for (int i = 0; i < 4; i++) step(1, next_sample(), 0, 0, 0, 0);
        end
        idle(2);

        // R8: second section, select switching, writes coincident with samples
        cur_req = "R8";
        step(0, 0, 1, 1, 6'h15, 0);
        for (int i = 0; i < 20; i++) step(1, next_sample(), 0, 0, 0, i % 2);
        for (int i = 0; i < 20; i++) step(1, next_sample(), 1, i % 2, i * 11, (i / 3) % 2);
        step(1, next_sample(), 1, 0, 6'h3F, 0);
        step(1, next_sample(), 0, 0, 0, 0);
        idle(2);

        // R9: full-scale extremes
        cur_req = "R9";
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 1, 6'h3F, 0);
        for (int i = 0; i < DEPTH + 2; i++) step(1, -128, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, -128, 0, 0, 0, 1);
        for (int i = 0; i < DEPTH + 2; i++) step(1, 127, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 127, 0, 0, 0, 1);
        idle(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule